// File: doc/BRIEF.md
# Range Maintenance Chunking Sequencer

This block turns one cache maintenance request into the sequence of register accesses that a maintenance command queue expects. The request carries a start address, an end address, an operation code, a target selector and a flag that asks for the whole cache. The sequencer first rounds the start down to a cache line and measures the range from there. When that measured distance comes within one line of wrapping the address space, it issues a single whole-cache operation instead. Otherwise it rounds the size up to whole lines and cuts it into chunks that never exceed a configured cap.

For every operation it clears the completion flag and writes the mode word. For a range it also writes the address and the size, and when the target is by way it writes the locked-way mask. It then reads the registration status and repeats the writes while the queue reports a failure. After a successful registration it polls the queue status until the status equals the completion flag alone. When the last operation has completed, it writes a sync primitive, reads it back and pulses `done`.

The bus side is a simple master. The sequencer holds each access until the queue model acknowledges it. Line size (as a power-of-two exponent), the per-operation limit and the locked-way mask are static configuration inputs.

Top module: `rmc_seq`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are all low.
- R2: The line size is 2^`cfg_line_log2`. The first range operation's address write (select 1) carries `req_start` rounded down to a line boundary. Each later chunk's address is the previous address plus the previous chunk size.
- R3: If `req_end` minus the aligned start, taken modulo 2^32, is at least 2^32 minus the line size, exactly one registration is made, with scope 1. It has no address or size writes.
- R4: Otherwise the chunk sizes add up to that distance rounded up to a line multiple. A distance of zero gives no registration at all, only the closing sync.
- R5: Each chunk size (select 2) is the smaller of the remaining size and `cfg_op_limit` minus the line size.
- R6: A registration first writes 4 to select 5 (clear completion). It then writes select 0 with the mode word: op in bits [2:0], scope in bits [5:4] (0 range, 1 whole), target in bits [7:6], and bit 8 set to 1. For a range it then writes select 1 and select 2. For target value 2 it then writes `cfg_lock_ways` to select 3. Finally it reads select 4.
- R7: If the select 4 read has bit 0 or bit 1 set, the writes repeat from the mode write, without a new clear.
- R8: After a clean registration, select 5 is read repeatedly until its value is exactly 4.
- R9: After the last operation, 8 is written to select 6 and select 6 is read. `done` is high for exactly one cycle, in the cycle after that read is acknowledged.
- R10: A request is taken only while `busy` is low. `req_valid` while busy causes no access.
- R11: While `bus_req` is high and not acknowledged, select, direction and write data stay stable.
- R12: `req_all` forces the whole-cache path of R3 whatever the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a request (taken when idle) |
| req_start | input | 32 | Range start address |
| req_end | input | 32 | Range end address |
| req_op | input | 3 | Operation code |
| req_tgt | input | 2 | Target selector (2 = by way) |
| req_all | input | 1 | Force whole-cache operation |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_line_log2 | input | 5 | Log2 of line size in bytes |
| cfg_op_limit | input | 32 | Per-operation size limit |
| cfg_lock_ways | input | 8 | Locked-way mask |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_sel | output | 3 | Register select |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | One-cycle access acknowledge |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
A request is accepted at the first rising edge where `req_valid` is high and the block is idle. Each bus access advances on the rising edge that samples its acknowledge, so the next access can show on the following falling edge. `done` is due one cycle after the acknowledge of the sync read-back. The bench drives the acknowledge and samples every output on falling edges. It logs each acknowledged access together with its cycle number, and checks the `done` cycle against the logged acknowledge cycle of the final read. Instead of timing individual accesses, it compares the complete ordered access stream with a stream rebuilt arithmetically from the request and the queue model's deterministic failure and poll schedule.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PLAN,
        ST_CLR,
        ST_MODE,
        ST_ADDR,
        ST_SIZE,
        ST_WAYS,
        ST_RSTAT,
        ST_POLL,
        ST_ADV,
        ST_SYNCW,
        ST_SYNCR,
        ST_DONE
    } seq_state_e;

    // register selects on the queue bus
    localparam logic [2:0] SEL_MODE  = 3'd0;
    localparam logic [2:0] SEL_ADDR  = 3'd1;
    localparam logic [2:0] SEL_SIZE  = 3'd2;
    localparam logic [2:0] SEL_WAYS  = 3'd3;
    localparam logic [2:0] SEL_RSTAT = 3'd4;
    localparam logic [2:0] SEL_QSTAT = 3'd5;
    localparam logic [2:0] SEL_PRIM  = 3'd6;

    // mode word layout
    localparam int MW_OP_LSB     = 0;
    localparam int MW_SCOPE_LSB  = 4;
    localparam int MW_TGT_LSB    = 6;
    localparam int MW_NOTIFY_BIT = 8;

    localparam logic [1:0] SCOPE_RANGE = 2'd0;
    localparam logic [1:0] SCOPE_WHOLE = 2'd1;
    localparam logic [1:0] TGT_BY_WAY  = 2'd2;

    localparam int QS_DONE_VAL  = 4;
    localparam int SYNC_VAL     = 8;
    localparam int RS_FAIL_MASK = 3;

endpackage

// File: rtl/rmc_range_prep.sv
module rmc_range_prep #(
    parameter int ADDR_W = 32,
    parameter int LG_W   = 5
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [LG_W-1:0]   line_log2,
    output logic [ADDR_W-1:0] line_bytes,
    output logic [ADDR_W-1:0] line_mask,
    output logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] size_rnd,
    output logic              wraps
);
    logic [ADDR_W-1:0] raw_size;
    logic [ADDR_W-1:0] neg_line;

    always_comb begin
        line_bytes = {{(ADDR_W-1){1'b0}}, 1'b1} << line_log2;
        line_mask  = line_bytes - {{(ADDR_W-1){1'b0}}, 1'b1};
        base_addr  = start_addr & ~line_mask;
        raw_size   = end_addr - base_addr;
        neg_line   = '0 - line_bytes;
        wraps      = (raw_size >= neg_line);
        size_rnd   = (raw_size + line_mask) & ~line_mask;
    end

endmodule

// File: rtl/rmc_chunk_pick.sv
module rmc_chunk_pick #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] remaining,
    input  logic [ADDR_W-1:0] op_limit,
    input  logic [ADDR_W-1:0] line_bytes,
    output logic [ADDR_W-1:0] chunk
);
    logic [ADDR_W-1:0] cap;

    always_comb begin
        cap   = op_limit - line_bytes;
        chunk = (remaining < cap) ? remaining : cap;
    end

endmodule

// File: rtl/rmc_seq.sv
module rmc_seq
    import rmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LG_W   = 5,
    parameter int WAYS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    input  logic [2:0]        req_op,
    input  logic [1:0]        req_tgt,
    input  logic              req_all,
    output logic              busy,
    output logic              done,
    input  logic [LG_W-1:0]   cfg_line_log2,
    input  logic [ADDR_W-1:0] cfg_op_limit,
    input  logic [WAYS-1:0]   cfg_lock_ways,
    output logic              bus_req,
    output logic              bus_we,
    output logic [2:0]        bus_sel,
    output logic [ADDR_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [ADDR_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] QS_DONE = ADDR_W'(QS_DONE_VAL);
    localparam logic [ADDR_W-1:0] SYNC_W  = ADDR_W'(SYNC_VAL);
    localparam logic [ADDR_W-1:0] RS_FAIL = ADDR_W'(RS_FAIL_MASK);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] rem;
        logic [ADDR_W-1:0] chunk;
        logic              whole;
        logic [2:0]        op;
        logic [1:0]        tgt;
    } seq_t;

    seq_t s_d, s_q;

    logic [ADDR_W-1:0] line_bytes, line_mask, base_addr, size_rnd, next_chunk;
    logic              wraps;
    logic [ADDR_W-1:0] mode_word;
    logic              by_way;

    rmc_range_prep #(.ADDR_W(ADDR_W), .LG_W(LG_W)) u_prep (
        .start_addr (req_start),
        .end_addr   (req_end),
        .line_log2  (cfg_line_log2),
        .line_bytes (line_bytes),
        .line_mask  (line_mask),
        .base_addr  (base_addr),
        .size_rnd   (size_rnd),
        .wraps      (wraps)
    );

    rmc_chunk_pick #(.ADDR_W(ADDR_W)) u_pick (
        .remaining  (s_q.rem),
        .op_limit   (cfg_op_limit),
        .line_bytes (line_bytes),
        .chunk      (next_chunk)
    );

    assign by_way = (s_q.tgt == TGT_BY_WAY);

    always_comb begin
        mode_word = '0;
        mode_word[MW_OP_LSB +: 3]    = s_q.op;
        mode_word[MW_SCOPE_LSB +: 2] = s_q.whole ? SCOPE_WHOLE : SCOPE_RANGE;
        mode_word[MW_TGT_LSB +: 2]   = s_q.tgt;
        mode_word[MW_NOTIFY_BIT]     = 1'b1;
    end

    // next-state process
    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.addr  = base_addr;
                    s_d.rem   = size_rnd;
                    s_d.whole = req_all | wraps;
                    s_d.op    = req_op;
                    s_d.tgt   = req_tgt;
                    s_d.st    = ST_PLAN;
                end
            end
            ST_PLAN: begin
                if (s_q.whole) begin
                    s_d.st = ST_CLR;
                end else if (s_q.rem == '0) begin
                    s_d.st = ST_SYNCW;
                end else begin
                    s_d.chunk = next_chunk;
                    s_d.st    = ST_CLR;
                end
            end
            ST_CLR:  if (bus_ack) s_d.st = ST_MODE;
            ST_MODE: begin
                if (bus_ack) begin
                    if (!s_q.whole)  s_d.st = ST_ADDR;
                    else if (by_way) s_d.st = ST_WAYS;
                    else             s_d.st = ST_RSTAT;
                end
            end
            ST_ADDR: if (bus_ack) s_d.st = ST_SIZE;
            ST_SIZE: if (bus_ack) s_d.st = by_way ? ST_WAYS : ST_RSTAT;
            ST_WAYS: if (bus_ack) s_d.st = ST_RSTAT;
            ST_RSTAT: begin
                if (bus_ack) begin
                    s_d.st = ((bus_rdata & RS_FAIL) != '0) ? ST_MODE : ST_POLL;
                end
            end
            ST_POLL: begin
                if (bus_ack && bus_rdata == QS_DONE) begin
                    s_d.st = s_q.whole ? ST_SYNCW : ST_ADV;
                end
            end
            ST_ADV: begin
                s_d.addr = s_q.addr + s_q.chunk;
                s_d.rem  = s_q.rem - s_q.chunk;
                s_d.st   = ST_PLAN;
            end
            ST_SYNCW: if (bus_ack) s_d.st = ST_SYNCR;
            ST_SYNCR: if (bus_ack) s_d.st = ST_DONE;
            ST_DONE:  s_d.st = ST_IDLE;
            default:  s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, addr: '0, rem: '0, chunk: '0,
                     whole: 1'b0, op: 3'd0, tgt: 2'd0};
        end else begin
            s_q <= s_d;
        end
    end

    // bus drive decoded from registered state
    always_comb begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_sel   = SEL_MODE;
        bus_wdata = '0;
        unique case (s_q.st)
            ST_CLR:   begin bus_sel = SEL_QSTAT; bus_wdata = QS_DONE; end
            ST_MODE:  begin bus_sel = SEL_MODE;  bus_wdata = mode_word; end
            ST_ADDR:  begin bus_sel = SEL_ADDR;  bus_wdata = s_q.addr; end
            ST_SIZE:  begin bus_sel = SEL_SIZE;  bus_wdata = s_q.chunk; end
            ST_WAYS:  begin
                bus_sel   = SEL_WAYS;
                bus_wdata = {{(ADDR_W-WAYS){1'b0}}, cfg_lock_ways};
            end
            ST_RSTAT: begin bus_sel = SEL_RSTAT; bus_we = 1'b0; end
            ST_POLL:  begin bus_sel = SEL_QSTAT; bus_we = 1'b0; end
            ST_SYNCW: begin bus_sel = SEL_PRIM;  bus_wdata = SYNC_W; end
            ST_SYNCR: begin bus_sel = SEL_PRIM;  bus_we = 1'b0; end
            default:  begin bus_req = 1'b0; bus_we = 1'b0; end
        endcase
    end

    assign busy = (s_q.st != ST_IDLE);
    assign done = (s_q.st == ST_DONE);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_req && bus_ack && !bus_we && bus_sel == SEL_PRIM));

    // R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_sel) && $stable(bus_we)
                                   && $stable(bus_wdata)));

    // R5
    chunk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_sel == SEL_SIZE) |->
            (bus_wdata != '0 && (bus_wdata & line_mask) == '0
             && bus_wdata <= cfg_op_limit - line_bytes));

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_sel == SEL_ADDR) |-> ((bus_wdata & line_mask) == '0));

    // R7
    retry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_sel == SEL_RSTAT && (bus_rdata & RS_FAIL) != '0)
            |=> (bus_req && bus_we && bus_sel == SEL_MODE));

    // R8
    poll_again_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && !bus_we && bus_sel == SEL_QSTAT && bus_rdata != QS_DONE)
            |=> (bus_req && !bus_we && bus_sel == SEL_QSTAT));

    // R10
    accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

endmodule

// File: tb/test_rmc_seq.sv
`timescale 1ns/1ps
module test_rmc_seq;
    localparam int LOGN = 16384;
    localparam int EXPN = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_start = '0, req_end = '0;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_tgt = '0;
    logic        req_all = 1'b0;
    logic        busy, done;
    logic [4:0]  cfg_lg = 5'd4;
    logic [31:0] cfg_lim = 32'd128;
    logic [7:0]  cfg_ways = 8'h5A;
    logic        bus_req, bus_we;
    logic [2:0]  bus_sel;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #2 clk = ~clk;

    rmc_seq i_rmc_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_start(req_start),
        .req_end(req_end), .req_op(req_op), .req_tgt(req_tgt), .req_all(req_all),
        .busy(busy), .done(done), .cfg_line_log2(cfg_lg), .cfg_op_limit(cfg_lim),
        .cfg_lock_ways(cfg_ways), .bus_req(bus_req), .bus_we(bus_we),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata)
    );

    // access log written by the queue model
    logic [2:0]  log_sel [LOGN];
    logic        log_we  [LOGN];
    logic [31:0] log_dat [LOGN];
    int log_n = 0, cyc = 0, ack_cyc = 0, done_cnt = 0, done_cyc = 0, dbl_done = 0;
    int hold_err = 0, acc = 0, wcnt = 0, kmod = 0, att = 0, pidx = 0, pc = 0;
    logic        prev_done = 1'b0;
    logic [2:0]  snap_sel;
    logic        snap_we;
    logic [31:0] snap_dat;

    // queue model: ack after 0..2 wait cycles, scheduled failures and polls
    always @(negedge clk) begin
        cyc++;
        if (done) begin
            if (prev_done) dbl_done++;
            done_cnt++;
            done_cyc = cyc;
        end
        prev_done = done;
        if (!rst_n) begin
            bus_ack = 1'b0;
            wcnt = 0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (wcnt == 0) begin
                snap_sel = bus_sel; snap_we = bus_we; snap_dat = bus_wdata;
            end else if (snap_sel != bus_sel || snap_we != bus_we || snap_dat != bus_wdata) begin
                hold_err++;
            end
            if (wcnt < acc % 3) begin
                wcnt++;
            end else begin
                wcnt = 0;
                acc++;
                bus_rdata = '0;
                if (!bus_we && bus_sel == 3'd4) begin
                    if (att < kmod % 3) begin
                        bus_rdata = (att % 2 == 0) ? 32'd2 : 32'd1;
                        att++;
                    end else begin
                        att = 0; pidx = kmod; kmod++; pc = 0;
                    end
                end else if (!bus_we && bus_sel == 3'd5) begin
                    if (pidx % 2 == 1) begin
                        bus_rdata = (pc == 0) ? 32'd1 : (pc == 1) ? 32'd5 : 32'd4;
                        pc++;
                    end else begin
                        bus_rdata = 32'd4;
                    end
                end else if (!bus_we && bus_sel == 3'd6) begin
                    bus_rdata = 32'd8;
                end
                if (log_n < LOGN) begin
                    log_sel[log_n] = bus_sel;
                    log_we[log_n]  = bus_we;
                    log_dat[log_n] = bus_we ? bus_wdata : 32'd0;
                    log_n++;
                end
                ack_cyc = cyc;
                bus_ack = 1'b1;
            end
        end
    end

    // expected stream
    logic [2:0]  exp_sel [EXPN];
    logic        exp_we  [EXPN];
    logic [31:0] exp_dat [EXPN];
    int exp_n = 0, kexp = 0, checks = 0, fails = 0;
    logic wd = 1'b0;

    task automatic push(input logic [2:0] s, input logic w, input logic [31:0] d);
        if (exp_n < EXPN) begin
            exp_sel[exp_n] = s; exp_we[exp_n] = w; exp_dat[exp_n] = d;
            exp_n++;
        end
    endtask

    task automatic push_reg(input logic whole, input logic [31:0] a, input logic [31:0] ch,
                            input logic [2:0] op, input logic [1:0] tg);
        logic [31:0] mw;
        int nf;
        mw = 32'h100 | (32'(tg) << 6) | (whole ? 32'h10 : 32'h0) | 32'(op);
        push(3'd5, 1'b1, 32'd4);
        nf = kexp % 3;
        for (int f = 0; f <= nf; f++) begin
            push(3'd0, 1'b1, mw);
            if (!whole) begin
                push(3'd1, 1'b1, a);
                push(3'd2, 1'b1, ch);
            end
            if (tg == 2'd2) push(3'd3, 1'b1, {24'd0, cfg_ways});
            push(3'd4, 1'b0, 32'd0);
        end
        for (int p = 0; p < ((kexp % 2 == 1) ? 3 : 1); p++) push(3'd5, 1'b0, 32'd0);
        kexp++;
    endtask

    task automatic gen_exp(input logic [31:0] s, input logic [31:0] e, input logic [2:0] op,
                           input logic [1:0] tg, input logic all);
        logic [31:0] line, base, raw, sz, a, ch, cap;
        line = 32'd1 << cfg_lg;
        base = s & ~(line - 32'd1);
        raw  = e - base;
        exp_n = 0;
        if (all || raw >= (32'd0 - line)) begin
            push_reg(1'b1, 32'd0, 32'd0, op, tg);
        end else begin
            sz  = (raw + line - 32'd1) & ~(line - 32'd1);
            a   = base;
            cap = cfg_lim - line;
            while (sz != 0) begin
                ch = (sz < cap) ? sz : cap;
                push_reg(1'b0, a, ch, op, tg);
                a  = a + ch;
                sz = sz - ch;
            end
        end
        push(3'd6, 1'b1, 32'd8);
        push(3'd6, 1'b0, 32'd0);
    endtask

    task automatic run_req(input logic [31:0] s, input logic [31:0] e, input logic [2:0] op,
                           input logic [1:0] tg, input logic all, input logic inject,
                           input string tag);
        int b, d0, t, first, nact, lg_before;
        if (wd) return;
        b  = log_n;
        d0 = done_cnt;
        gen_exp(s, e, op, tg, all);
        @(negedge clk);
        req_start = s; req_end = e; req_op = op; req_tgt = tg; req_all = all;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (done_cnt == d0 && t < 5000 && !wd) begin
            @(negedge clk);
            t++;
            if (inject && t == 5) begin
                req_start = s + 32'h4000; req_end = e + 32'h8000;
                req_op = op ^ 3'd7; req_all = !all; req_valid = 1'b1;
            end
            if (inject && t == 7) req_valid = 1'b0;
            if (cyc > 190000) wd = 1'b1;
        end
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (done_cnt == d0) begin
            fails++;
            $display("FAIL R9 %s: no done, actual 0 pulses expected 1", tag);
            return;
        end
        // ordered access stream
        checks++;
        nact = log_n - b;
        first = -1;
        for (int i = 0; i < exp_n && i < nact; i++) begin
            if (first < 0 && (b + i) < LOGN &&
                (log_sel[b+i] != exp_sel[i] || log_we[b+i] != exp_we[i] ||
                 log_dat[b+i] != exp_dat[i]))
                first = i;
        end
        if (nact != exp_n) begin
            fails++;
            $display("FAIL %s: stream length actual %0d expected %0d (start %h end %h)",
                     tag, nact, exp_n, s, e);
        end else if (first >= 0) begin
            fails++;
            $display("FAIL %s: access %0d actual sel%0d we%0d %h expected sel%0d we%0d %h",
                     tag, first, log_sel[b+first], log_we[b+first], log_dat[b+first],
                     exp_sel[first], exp_we[first], exp_dat[first]);
        end
        // R9 timing and single pulse
        checks++;
        if (done_cnt - d0 != 1 || done_cyc != ack_cyc + 1) begin
            fails++;
            $display("FAIL R9 %s: pulses %0d done cycle %0d, expected 1 pulse at %0d",
                     tag, done_cnt - d0, done_cyc, ack_cyc + 1);
        end
        if (inject) begin
            lg_before = log_n;
            repeat (30) @(negedge clk);
            checks++;
            if (log_n != lg_before || busy) begin
                fails++;
                $display("FAIL R10: extra accesses actual %0d expected 0, busy %0b expected 0",
                         log_n - lg_before, busy);
            end
        end
    endtask

    initial begin
        logic [31:0] line, cap, s, len, soff;
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (busy !== 1'b0 || done !== 1'b0 || bus_req !== 1'b0) begin
            fails++;
            $display("FAIL R1: busy %b done %b bus_req %b expected 0 0 0", busy, done, bus_req);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // sweep: line sizes, start offsets, lengths around line and chunk limits
        for (int g = 4; g <= 6; g++) begin
            cfg_lg   = 5'(g);
            line     = 32'd1 << g;
            cfg_lim  = 8 * line;
            cap      = cfg_lim - line;
            cfg_ways = 8'h5A ^ 8'(g);
            for (int si = 0; si < 5; si++) begin
                for (int li = 0; li < 8; li++) begin
                    case (si)
                        0: soff = 0;
                        1: soff = 1;
                        2: soff = line / 2;
                        3: soff = line - 1;
                        default: soff = line + 3;
                    endcase
                    case (li)
                        0: len = 0;
                        1: len = 1;
                        2: len = line - 1;
                        3: len = line;
                        4: len = line + 1;
                        5: len = cap;
                        6: len = cap + 1;
                        default: len = 3 * cap + 5;
                    endcase
                    s = 32'h1000 + soff;
                    run_req(s, s + len, 3'((si * 8 + li) % 8), 2'((si + li + g) % 3),
                            1'b0, 1'b0, "R2 R4 R5 R6 R7 R8");
                end
            end
        end

        cfg_lg = 5'd4; cfg_lim = 32'd128; cfg_ways = 8'hC3;
        // R3: distance exactly 2^32 - line
        run_req(32'h2005, 32'h2000 - 32'd16, 3'd2, 2'd0, 1'b0, 1'b0, "R3 exact wrap");
        // R3: distance 2^32 - 1, by-way target
        run_req(32'h2005, 32'h1FFF, 3'd5, 2'd2, 1'b0, 1'b0, "R3 wrap by way R6");
        // R4: zero distance, sync only
        run_req(32'h2000, 32'h2000, 3'd1, 2'd0, 1'b0, 1'b0, "R4 zero size");
        // R2 R4: end below start inside the same line
        run_req(32'h2008, 32'h2004, 3'd0, 2'd1, 1'b0, 1'b0, "R2 R4 end below start");
        // R12: whole-cache forced
        run_req(32'h3000, 32'h3100, 3'd1, 2'd1, 1'b1, 1'b0, "R12 forced whole");
        // R10: request pulse while busy is ignored
        run_req(32'h4010, 32'h4200, 3'd2, 2'd0, 1'b0, 1'b1, "R10 busy ignore");

        // R11 hold and R9 single-cycle pulse over the whole run
        checks++;
        if (hold_err != 0) begin
            fails++;
            $display("FAIL R11: hold violations actual %0d expected 0", hold_err);
        end
        checks++;
        if (dbl_done != 0) begin
            fails++;
            $display("FAIL R9: multi-cycle done actual %0d expected 0", dbl_done);
        end
        if (wd) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run stalled, actual hung expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule